// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Word Deserializer

This block turns a one-bit serial stream, clocked at the bit rate, into a parallel word that changes once per word period. The number of bits per word, M, is a runtime input between 4 and 40. The storage is built from ten-bit slices that are chained in series. Each slice passes its oldest bit on to the next slice, so a chain of `NUM_SLICES` slices recovers words up to `10*NUM_SLICES` bits wide. The bit shifted out of the far end of the chain is available on a cascade output, which can feed another instance.

A word-boundary strobe marks the last bit of each word. On that edge the stored bits are copied into a parallel holding register, which keeps its value for the whole next word period. A lock/valid input qualifies everything on the parallel side. While lock is low, the words and the recovered word clock are forced off and word framing restarts. After lock returns, the first strobe only opens a word. The first real word is delivered at the strobe after that. Separate enables switch off the parallel side and the cascade output.

Top module: `deser_chain`

## Requirements
- R1: While reset is asserted, `par_out` is all zeros and `dclk_out` and `cas_out` are low, whatever the enables and lock inputs are.
- R2: When lock and `par_en` are high and a strobe is sampled with the last bit of a word, the next clock edge puts the j-th received bit of that word (j = 0 is the first) on `par_out[M-1-j]`. The word then holds until the next strobe.
- R3: Every `par_out` position at or above M reads zero, including whole slices that lie beyond M.
- R4: The smallest ratio, M = 4, and the largest, M = 40, both frame and deliver words correctly.
- R5: After lock rises, the first strobe delivers nothing: `par_out` stays zero and `dclk_out` stays low until that strobe. Data appears from the second strobe onward.
- R6: While lock is low, `par_out` is zero and `dclk_out` is low in the same cycle, with no clock edge needed. Any partial word is discarded.
- R7: While `par_en` is low, `par_out` is zero and `dclk_out` is low. The held word is untouched and reappears as soon as `par_en` returns high.
- R8: With `cas_en` high, `cas_out` equals the serial bit received `10*NUM_SLICES` bit clocks earlier, independent of lock, M and strobes. With `cas_en` low, `cas_out` is low.
- R9: Once words are flowing, `dclk_out` is high for the first floor(M/2) bit clocks after each strobe edge and low for the rest of the word period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial data, one bit per clock |
| word_strb | input | 1 | High in the clock that carries the last bit of a word |
| lock_ok | input | 1 | Lock/valid qualifier for the parallel side |
| ratio_m | input | RATIO_W (6) | Bits per word M, 4 to 40 |
| par_en | input | 1 | Enable for parallel data and word clock |
| cas_en | input | 1 | Enable for the cascade output |
| cas_out | output | 1 | Bit shifted out of the last slice |
| par_out | output | 10*NUM_SLICES (40) | Recovered parallel word |
| dclk_out | output | 1 | Recovered word clock |

## Verification
If the bit order or a slice link is wrong, a misplaced or stale bit shows on `par_out` on the first clock edge after the strobe that ends a word. The scoreboard compares every delivered word against the bits it drove. A fault in the word-phase counter or the framing state appears on `dclk_out` within the same word period, as a wrong high length or a pulse before framing starts. A fault in the cascade path shows on `cas_out` one chain-length of bits after the affected bit enters. Gating faults are exposed at the very cycle lock or an enable falls.

// File: rtl/deser_pkg.sv
`timescale 1ns/1ps
package deser_pkg;

   localparam int SLICE_W = 10;

   typedef enum logic {
      TS_WAIT = 1'b0,
      TS_RUN  = 1'b1
   } frame_state_e;

   function automatic int ratio_bits(input int max_ratio);
      return $clog2(max_ratio + 1);
   endfunction

endpackage

// File: rtl/deser_slice.sv
`timescale 1ns/1ps
module deser_slice #(
   parameter int W       = 10,
   parameter int IDX     = 0,
   parameter int RATIO_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cas_i,
   input  logic [RATIO_W-1:0] ratio_i,
   input  logic               load_i,
   input  logic               clr_i,
   output logic               cas_o,
   output logic [W-1:0]       word_o
);

   localparam int BASE = IDX * W;

   logic [W-1:0] shift_q;
   logic [W-1:0] shift_d;
   logic [W-1:0] keep;
   logic [W-1:0] word_q;

   assign shift_d = {shift_q[W-2:0], cas_i};

   for (genvar i = 0; i < W; i++) begin : g_keep
      assign keep[i] = (BASE + i) < int'(ratio_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift_q <= '0;
      end else begin
         shift_q <= shift_d;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (clr_i) begin
         word_q <= '0;
      end else if (load_i) begin
         word_q <= shift_d & keep;
      end
   end

   assign cas_o  = shift_q[W-1];
   assign word_o = word_q;

endmodule

// File: rtl/deser_word_timer.sv
`timescale 1ns/1ps
module deser_word_timer
   import deser_pkg::*;
#(
   parameter int RATIO_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lock_i,
   input  logic               strb_i,
   input  logic [RATIO_W-1:0] ratio_i,
   output logic               load_o,
   output logic               clr_o,
   output logic               dclk_o
);

   localparam logic [RATIO_W-1:0] PH_MAX = '1;

   frame_state_e        state_q;
   logic [RATIO_W-1:0]  phase_q;
   logic [RATIO_W-1:0]  half_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= TS_WAIT;
      end else if (!lock_i) begin
         state_q <= TS_WAIT;
      end else if (strb_i) begin
         state_q <= TS_RUN;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (!lock_i || strb_i) begin
         phase_q <= '0;
      end else if (phase_q != PH_MAX) begin
         phase_q <= phase_q + 1'b1;
      end
   end

   assign half_len = ratio_i >> 1;
   assign load_o   = lock_i && strb_i && (state_q == TS_RUN);
   assign clr_o    = !lock_i;
   assign dclk_o   = (state_q == TS_RUN) && (phase_q < half_len);

endmodule

// File: rtl/deser_out_gate.sv
`timescale 1ns/1ps
module deser_out_gate #(
   parameter int TOT_W = 40
) (
   input  logic             lock_i,
   input  logic             par_en_i,
   input  logic             cas_en_i,
   input  logic [TOT_W-1:0] word_i,
   input  logic             dclk_i,
   input  logic             cas_i,
   output logic [TOT_W-1:0] word_o,
   output logic             dclk_o,
   output logic             cas_o
);

   logic par_live;

   assign par_live = lock_i && par_en_i;
   assign word_o   = par_live ? word_i : '0;
   assign dclk_o   = par_live && dclk_i;
   assign cas_o    = cas_en_i && cas_i;

endmodule

// File: rtl/deser_chain.sv
`timescale 1ns/1ps
module deser_chain
   import deser_pkg::*;
#(
   parameter int NUM_SLICES = 4,
   parameter int MIN_RATIO  = 4,
   parameter int MAX_RATIO  = 40,
   parameter int RATIO_W    = $clog2(MAX_RATIO + 1)
) (
   input  logic                          clk_bit,
   input  logic                          rst_n,
   input  logic                          ser_in,
   input  logic                          word_strb,
   input  logic                          lock_ok,
   input  logic [RATIO_W-1:0]            ratio_m,
   input  logic                          par_en,
   input  logic                          cas_en,
   output logic                          cas_out,
   output logic [NUM_SLICES*SLICE_W-1:0] par_out,
   output logic                          dclk_out
);

   localparam int TOT_W = NUM_SLICES * SLICE_W;

   initial begin : p_param_chk
      assert (NUM_SLICES >= 1)
         else $fatal(1, "deser_chain: NUM_SLICES must be at least 1");
      assert (MIN_RATIO >= 2 && MIN_RATIO <= MAX_RATIO)
         else $fatal(1, "deser_chain: ratio bounds inconsistent");
      assert (MAX_RATIO <= TOT_W)
         else $fatal(1, "deser_chain: chain too short for MAX_RATIO");
      assert (RATIO_W >= ratio_bits(MAX_RATIO))
         else $fatal(1, "deser_chain: RATIO_W too narrow");
   end

   logic [NUM_SLICES:0] cas_link;
   logic [TOT_W-1:0]    word_all;
   logic                load;
   logic                clr;
   logic                dclk_raw;

   assign cas_link[0] = ser_in;

   deser_word_timer #(.RATIO_W(RATIO_W)) u_timer (
      .clk     (clk_bit),
      .rst_n   (rst_n),
      .lock_i  (lock_ok),
      .strb_i  (word_strb),
      .ratio_i (ratio_m),
      .load_o  (load),
      .clr_o   (clr),
      .dclk_o  (dclk_raw)
   );

   for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      deser_slice #(
         .W       (SLICE_W),
         .IDX     (s),
         .RATIO_W (RATIO_W)
      ) u_slice (
         .clk     (clk_bit),
         .rst_n   (rst_n),
         .cas_i   (cas_link[s]),
         .ratio_i (ratio_m),
         .load_i  (load),
         .clr_i   (clr),
         .cas_o   (cas_link[s+1]),
         .word_o  (word_all[s*SLICE_W +: SLICE_W])
      );
   end

   deser_out_gate #(.TOT_W(TOT_W)) u_gate (
      .lock_i   (lock_ok),
      .par_en_i (par_en),
      .cas_en_i (cas_en),
      .word_i   (word_all),
      .dclk_i   (dclk_raw),
      .cas_i    (cas_link[NUM_SLICES]),
      .word_o   (par_out),
      .dclk_o   (dclk_out),
      .cas_o    (cas_out)
   );

endmodule

// File: rtl/deser_chain_chk.sv
`timescale 1ns/1ps
module deser_chain_chk #(
   parameter int TOT_W   = 40,
   parameter int RATIO_W = 6
) (
   input logic               clk_bit,
   input logic               rst_n,
   input logic               word_strb,
   input logic               lock_ok,
   input logic [RATIO_W-1:0] ratio_m,
   input logic               par_en,
   input logic               cas_en,
   input logic               cas_out,
   input logic [TOT_W-1:0]   par_out,
   input logic               dclk_out
);

   logic               seen;
   logic [RATIO_W-1:0] hi_len;
   logic               unused_hit;

   always_ff @(posedge clk_bit) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   always_ff @(posedge clk_bit) begin
      if (!rst_n)              hi_len <= '0;
      else if (!dclk_out)      hi_len <= '0;
      else if (hi_len != '1)   hi_len <= hi_len + 1'b1;
   end

   always_comb begin
      unused_hit = 1'b0;
      for (int g = 0; g < TOT_W; g++) begin
         if (g >= int'(ratio_m) && par_out[g]) unused_hit = 1'b1;
      end
   end

   // R1
   a_r1_reset_quiet: assert property (@(posedge clk_bit)
      !rst_n |=> (!rst_n |-> (par_out == '0 && !dclk_out)));

   // R2
   a_r2_word_hold: assert property (@(posedge clk_bit) disable iff (!rst_n)
      (seen && lock_ok && par_en && $past(lock_ok) && $past(par_en)
       && !$past(word_strb)) |-> $stable(par_out));

   // R3
   a_r3_unused_zero: assert property (@(posedge clk_bit) disable iff (!rst_n)
      !unused_hit);

   // R5
   a_r5_first_word_quiet: assert property (@(posedge clk_bit) disable iff (!rst_n)
      (seen && $rose(lock_ok)) |-> (par_out == '0 && !dclk_out));

   // R6
   a_r6_lock_low_off: assert property (@(posedge clk_bit) disable iff (!rst_n)
      !lock_ok |-> (par_out == '0 && !dclk_out));

   // R7
   a_r7_par_disabled: assert property (@(posedge clk_bit) disable iff (!rst_n)
      !par_en |-> (par_out == '0 && !dclk_out));

   // R8
   a_r8_cas_disabled: assert property (@(posedge clk_bit) disable iff (!rst_n)
      !cas_en |-> !cas_out);

   // R9
   a_r9_dclk_width: assert property (@(posedge clk_bit) disable iff (!rst_n)
      dclk_out |-> (hi_len < (ratio_m >> 1)));

endmodule

bind deser_chain deser_chain_chk #(
   .TOT_W   (NUM_SLICES * deser_pkg::SLICE_W),
   .RATIO_W (RATIO_W)
) u_chk (
   .clk_bit   (clk_bit),
   .rst_n     (rst_n),
   .word_strb (word_strb),
   .lock_ok   (lock_ok),
   .ratio_m   (ratio_m),
   .par_en    (par_en),
   .cas_en    (cas_en),
   .cas_out   (cas_out),
   .par_out   (par_out),
   .dclk_out  (dclk_out)
);

// File: tb/deser_chain_bench.sv
`timescale 1ns/1ps
module deser_chain_bench;

   localparam int TOT = 40;

   logic            clk_bit = 1'b0;
   logic            rst_n   = 1'b0;
   logic            ser_in  = 1'b0;
   logic            word_strb = 1'b0;
   logic            lock_ok = 1'b0;
   logic [5:0]      ratio_m = 6'd10;
   logic            par_en  = 1'b0;
   logic            cas_en  = 1'b0;
   logic            cas_out;
   logic [TOT-1:0]  par_out;
   logic            dclk_out;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   int cas_mode = 0;             // 0 off, 1 history, 2 expect low

   logic [TOT-1:0]  exq[$];
   string           extag[$];
   logic [TOT-1:0]  last_exp = '0;
   logic            hist[$];

   always #2 clk_bit = ~clk_bit;

   deser_chain u_deser_chain (
      .clk_bit  (clk_bit),
      .rst_n    (rst_n),
      .ser_in   (ser_in),
      .word_strb(word_strb),
      .lock_ok  (lock_ok),
      .ratio_m  (ratio_m),
      .par_en   (par_en),
      .cas_en   (cas_en),
      .cas_out  (cas_out),
      .par_out  (par_out),
      .dclk_out (dclk_out)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [TOT-1:0] mapw(input int m, input logic [TOT-1:0] d);
      logic [TOT-1:0] r = '0;
      for (int j = 0; j < m; j++) r[m-1-j] = d[j];
      return r;
   endfunction

   // one bit clock: sample at negedge, then drive
   task automatic step(input logic b, input logic s, input int dexp);
      @(negedge clk_bit);
      if (cas_mode == 1 && hist.size() >= TOT)
         chk(cas_out === hist[hist.size()-TOT], "R8 cascade",
             {63'd0, cas_out}, {63'd0, hist[hist.size()-TOT]});
      else if (cas_mode == 2)
         chk(cas_out === 1'b0, "R8 cascade off", {63'd0, cas_out}, 64'd0);
      if (dexp >= 0)
         chk(dclk_out === dexp[0], "R9 dclk phase", {63'd0, dclk_out}, dexp);
      ser_in    = b;
      word_strb = s;
      hist.push_back(b);
   endtask

   // mode 0: no dclk check; 1: first word after lock; 2: full dclk pattern
   task automatic send_word(input int m, input logic [TOT-1:0] d, input int mode);
      logic [TOT-1:0] e;
      string tag;
      e = (mode == 1) ? '0 : mapw(m, d);
      if (mode == 1)           tag = "R5 first word";
      else if (m == 4 || m == 40) tag = "R4 ratio edge";
      else if (m % 10 != 0)    tag = "R3 unused zero";
      else                     tag = "R2 word";
      exq.push_back(e);
      extag.push_back(tag);
      for (int j = 0; j < m; j++) begin
         int de;
         if (mode == 1)      de = 0;
         else if (mode == 2) de = (j < m/2) ? 1 : 0;
         else                de = -1;
         if (mode == 1 && j == 1)
            chk(par_out === '0, "R5 quiet before data", {24'd0, par_out}, 64'd0);
         step(d[j], (j == m-1), de);
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(1'b1, 1'b0, -1);
   endtask

   task automatic run_ratio(input int m, input int words);
      step(1'b0, 1'b0, -1);
      lock_ok = 1'b0;
      idle(2);
      ratio_m = m[5:0];
      lock_ok = 1'b1;
      send_word(m, {$urandom, $urandom}, 1);
      for (int w = 0; w < words; w++) send_word(m, {$urandom, $urandom}, 2);
   endtask

   // scoreboard monitor
   always begin
      logic s;
      @(posedge clk_bit);
      s = word_strb && lock_ok;
      #1;
      if (s) begin
         if (exq.size() == 0) begin
            chk(1'b0, "R2 unexpected load", {24'd0, par_out}, 64'd0);
         end else begin
            logic [TOT-1:0] e;
            string t;
            e = exq.pop_front();
            t = extag.pop_front();
            last_exp = e;
            chk(par_out === e, t, {24'd0, par_out}, {24'd0, e});
         end
      end
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk_bit);
      if (!done) begin
         chk(1'b0, "watchdog", 64'd0, 64'd1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      lock_ok = 1'b1;
      par_en  = 1'b1;
      cas_en  = 1'b1;
      ser_in  = 1'b1;
      repeat (4) @(negedge clk_bit);
      #1;
      // R1
      chk(par_out === '0, "R1 reset par", {24'd0, par_out}, 64'd0);
      chk(dclk_out === 1'b0, "R1 reset dclk", {63'd0, dclk_out}, 64'd0);
      chk(cas_out === 1'b0, "R1 reset cas", {63'd0, cas_out}, 64'd0);
      @(negedge clk_bit);
      rst_n = 1'b1;
      cas_mode = 1;

      // R2, R5: M = 10
      send_word(10, {$urandom, $urandom}, 1);
      send_word(10, 40'h00_0000_02A5, 2);
      send_word(10, 40'h00_0000_03FF, 2);
      send_word(10, 40'h00_0000_0001, 2);

      // R4: smallest and largest ratio
      run_ratio(4, 4);
      run_ratio(40, 3);
      send_word(40, 40'h80_0000_0001, 2);

      // R3 and R9 with odd ratios
      run_ratio(15, 3);
      run_ratio(23, 3);
      run_ratio(7, 3);

      // R7: parallel enable
      run_ratio(15, 2);
      step(1'b0, 1'b0, -1);
      par_en = 1'b0;
      #1;
      chk(par_out === '0, "R7 par off", {24'd0, par_out}, 64'd0);
      chk(dclk_out === 1'b0, "R7 dclk off", {63'd0, dclk_out}, 64'd0);
      idle(3);
      chk(par_out === '0, "R7 par still off", {24'd0, par_out}, 64'd0);
      step(1'b0, 1'b0, -1);
      par_en = 1'b1;
      #1;
      chk(par_out === last_exp, "R7 held word back", {24'd0, par_out}, {24'd0, last_exp});
      send_word(15, {$urandom, $urandom}, 0);
      send_word(15, {$urandom, $urandom}, 2);

      // R8: cascade disable
      step(1'b1, 1'b0, -1);
      cas_en = 1'b0;
      cas_mode = 2;
      idle(12);
      cas_en = 1'b1;
      cas_mode = 1;
      idle(3);

      // R6: lock lost in mid-word
      run_ratio(10, 2);
      for (int k = 0; k < 5; k++) step(1'b1, 1'b0, -1);
      lock_ok = 1'b0;
      #1;
      chk(par_out === '0, "R6 lock low par", {24'd0, par_out}, 64'd0);
      chk(dclk_out === 1'b0, "R6 lock low dclk", {63'd0, dclk_out}, 64'd0);
      idle(4);
      chk(par_out === '0, "R6 lock low held", {24'd0, par_out}, 64'd0);
      lock_ok = 1'b1;
      #1;
      chk(par_out === '0, "R6 no stale word", {24'd0, par_out}, 64'd0);
      send_word(10, {$urandom, $urandom}, 1);
      send_word(10, 40'h00_0000_0155, 2);
      send_word(10, {$urandom, $urandom}, 2);

      step(1'b0, 1'b0, -1);
      idle(3);
      chk(exq.size() == 0, "R2 all words seen", exq.size(), 64'd0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule